// File: doc/BRIEF.md
# Steam Pressure Regulator with Derivative Feedback

This block is a fixed-point pressure regulator for a turbine control loop. On every work-cycle strobe, nominally one every 5 ms, it samples three signed values: the current steam pressure, the pressure setpoint and the electrical power. From these it forms a control impact. The impact is the pressure error plus two derivative terms. One derivative term follows the pressure and the other follows the power. Each derivative term is weighted by the product of its own transfer ratio and its own derivative time constant.

Each derivative is a backward difference between the present sample and the last valid one. The reciprocal of the cycle period is folded into the gain, so no division is needed. The summed impact is clamped to the output range, and a flag reports when clamping took place. The impact then drives a valve motor through two command bits. Increase is raised when the impact is above a programmable deadband. Decrease is raised when the impact is below the negative of that deadband.

If the measurements are marked invalid, the block issues no commands and the stored samples stay as they were. The first valid cycle after reset produces no derivative kick.

Top module: `turb_press_reg`

## Requirements
- R1: While reset is asserted and after reset is released, and before the first valid strobe: `impact` is 0, and `impact_sat`, `cmd_inc` and `cmd_dec` are all 0.
- R2: A strobe with `in_valid` high is captured at a rising edge, and the outputs show the result from that edge onward. The unclamped impact is y = (press_cur − press_ref) + floor(dP·press_gain·press_tc / 2^(2·FRAC)) + floor(dN·power_gain·power_tc / 2^(2·FRAC)). Here dP and dN are the present sample minus the stored sample of the same channel. The gains and time constants are signed two's-complement values with FRAC fraction bits.
- R3: On the first valid strobe after reset, dP and dN are taken as 0. After every valid strobe, the stored samples become the present samples.
- R4: If y lies outside the signed OUT_W-bit range, `impact` is clamped to the nearest limit and `impact_sat` is 1. Otherwise `impact` equals y and `impact_sat` is 0.
- R5: `cmd_inc` is 1 exactly when the clamped impact is greater than `deadband`. `cmd_dec` is 1 exactly when the clamped impact is less than −`deadband`. `deadband` is unsigned. The two commands are never 1 at the same time.
- R6: A strobe with `in_valid` low drives both commands to 0. It keeps `impact` and `impact_sat` unchanged, and it leaves the stored samples and the first-cycle state untouched.
- R7: In a cycle without a strobe, all outputs hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_tick | input | 1 | One-cycle strobe for each work cycle |
| in_valid | input | 1 | The measurements of this strobe are usable |
| press_cur | input | SMP_W | Current pressure, signed |
| press_ref | input | SMP_W | Pressure setpoint, signed |
| power_cur | input | SMP_W | Electrical power, signed |
| press_gain | input | GAIN_W | Pressure transfer ratio, signed, FRAC fraction bits |
| press_tc | input | GAIN_W | Pressure derivative time constant over the cycle period, signed, FRAC fraction bits |
| power_gain | input | GAIN_W | Power transfer ratio, signed, FRAC fraction bits |
| power_tc | input | GAIN_W | Power derivative time constant over the cycle period, signed, FRAC fraction bits |
| deadband | input | OUT_W-1 | Unsigned half-width of the no-command band |
| impact | output | OUT_W | Clamped control impact, signed |
| impact_sat | output | 1 | The last valid impact was clamped |
| cmd_inc | output | 1 | Increase command to the valve motor |
| cmd_dec | output | 1 | Decrease command to the valve motor |

## Verification
The hardest state to reach is an invalid strobe that falls between two valid ones. Its effect shows only on the following valid strobe, whose derivatives must be taken against the sample from before the gap. The stimulus therefore makes every fifth strobe invalid and changes the samples during that strobe. It also inserts idle cycles with fresh input values between strobes. Clamping is reached in the same sweep by switching between small-amplitude and full-range samples under gains of several units, so both limits are hit.

// File: rtl/turb_press_reg_pkg.sv
package turb_press_reg_pkg;

    // channel indices of the derivative paths
    localparam int CH_PRESS = 0;
    localparam int CH_POWER = 1;
    localparam int N_CH     = 2;

endpackage

// File: rtl/pr_diff.sv
module pr_diff #(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    valid,
    input  logic signed [SMP_W-1:0] sample,
    output logic signed [SMP_W:0]   diff
);

    typedef struct packed {
        logic signed [SMP_W-1:0] prev;
        logic                    primed;
    } diff_state_t;

    diff_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.primed) begin
            diff = (SMP_W+1)'(sample) - (SMP_W+1)'(st_q.prev);
        end else begin
            diff = '0;
        end
        if (tick && valid) begin
            st_d.prev   = sample;
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: an invalid strobe leaves the stored sample alone
    a_r6_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !valid) |=> $stable(st_q.prev) && $stable(st_q.primed));

    // R3: a valid strobe arms the derivative path
    a_r3_primed: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && valid) |=> st_q.primed);

endmodule

// File: rtl/pr_term.sv
module pr_term #(
    parameter int SMP_W  = 16,
    parameter int GAIN_W = 16,
    parameter int FRAC   = 8,
    localparam int PW    = SMP_W + 1 + 2 * GAIN_W,
    localparam int TW    = PW - 2 * FRAC
) (
    input  logic signed [SMP_W:0]    diff,
    input  logic signed [GAIN_W-1:0] gain,
    input  logic signed [GAIN_W-1:0] tconst,
    output logic signed [TW-1:0]     term
);

    logic signed [PW-1:0] op_d;
    logic signed [PW-1:0] op_k;
    logic signed [PW-1:0] op_t;
    logic signed [PW-1:0] prod;

    always_comb begin
        op_d = PW'(diff);
        op_k = PW'(gain);
        op_t = PW'(tconst);
        prod = op_d * op_k * op_t;
        term = TW'(prod >>> (2 * FRAC));
    end

endmodule

// File: rtl/pr_out.sv
module pr_out #(
    parameter int SUM_W = 35,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    valid,
    input  logic signed [SUM_W-1:0] sum,
    input  logic [OUT_W-2:0]        deadband,
    output logic signed [OUT_W-1:0] impact,
    output logic                    impact_sat,
    output logic                    cmd_inc,
    output logic                    cmd_dec
);

    localparam logic signed [SUM_W-1:0] Y_HI =
        signed'({{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] Y_LO =
        signed'({{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}});

    typedef struct packed {
        logic signed [OUT_W-1:0] y;
        logic                    sat;
        logic                    inc;
        logic                    dec;
    } out_state_t;

    out_state_t st_d, st_q;

    logic signed [OUT_W-1:0] y_clamp;
    logic                    y_sat;
    logic signed [OUT_W:0]   y_ext;
    logic signed [OUT_W:0]   db_pos;
    logic signed [OUT_W:0]   db_neg;

    always_comb begin
        y_sat = 1'b0;
        if (sum > Y_HI) begin
            y_clamp = OUT_W'(Y_HI);
            y_sat   = 1'b1;
        end else if (sum < Y_LO) begin
            y_clamp = OUT_W'(Y_LO);
            y_sat   = 1'b1;
        end else begin
            y_clamp = OUT_W'(sum);
        end
        y_ext  = (OUT_W+1)'(y_clamp);
        db_pos = signed'({2'b00, deadband});
        db_neg = -db_pos;

        st_d = st_q;
        if (tick) begin
            if (valid) begin
                st_d.y   = y_clamp;
                st_d.sat = y_sat;
                st_d.inc = (y_ext > db_pos);
                st_d.dec = (y_ext < db_neg);
            end else begin
                st_d.inc = 1'b0;
                st_d.dec = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign impact     = st_q.y;
    assign impact_sat = st_q.sat;
    assign cmd_inc    = st_q.inc;
    assign cmd_dec    = st_q.dec;

    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_inc && cmd_dec));

    a_r5_inc_sign: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_inc |-> (impact > 0));

    a_r5_dec_sign: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dec |-> (impact < 0));

    a_r4_sat_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        impact_sat |-> ((impact == OUT_W'(Y_HI)) || (impact == OUT_W'(Y_LO))));

    a_r6_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !valid) |=> (!cmd_inc && !cmd_dec && $stable(impact) && $stable(impact_sat)));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(impact) && $stable(impact_sat) && $stable(cmd_inc) && $stable(cmd_dec)));

endmodule

// File: rtl/turb_press_reg.sv
module turb_press_reg
    import turb_press_reg_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int GAIN_W = 16,
    parameter int FRAC   = 8,
    parameter int OUT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cycle_tick,
    input  logic                     in_valid,
    input  logic signed [SMP_W-1:0]  press_cur,
    input  logic signed [SMP_W-1:0]  press_ref,
    input  logic signed [SMP_W-1:0]  power_cur,
    input  logic signed [GAIN_W-1:0] press_gain,
    input  logic signed [GAIN_W-1:0] press_tc,
    input  logic signed [GAIN_W-1:0] power_gain,
    input  logic signed [GAIN_W-1:0] power_tc,
    input  logic [OUT_W-2:0]         deadband,
    output logic signed [OUT_W-1:0]  impact,
    output logic                     impact_sat,
    output logic                     cmd_inc,
    output logic                     cmd_dec
);

    localparam int PW    = SMP_W + 1 + 2 * GAIN_W;
    localparam int TW    = PW - 2 * FRAC;
    localparam int SUM_W = TW + 2;

    logic signed [SMP_W-1:0]  ch_smp  [N_CH];
    logic signed [GAIN_W-1:0] ch_gain [N_CH];
    logic signed [GAIN_W-1:0] ch_tc   [N_CH];
    logic signed [SMP_W:0]    ch_diff [N_CH];
    logic signed [TW-1:0]     ch_term [N_CH];

    assign ch_smp[CH_PRESS]  = press_cur;
    assign ch_smp[CH_POWER]  = power_cur;
    assign ch_gain[CH_PRESS] = press_gain;
    assign ch_gain[CH_POWER] = power_gain;
    assign ch_tc[CH_PRESS]   = press_tc;
    assign ch_tc[CH_POWER]   = power_tc;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pr_diff #(
            .SMP_W (SMP_W)
        ) u_diff (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (cycle_tick),
            .valid  (in_valid),
            .sample (ch_smp[c]),
            .diff   (ch_diff[c])
        );

        pr_term #(
            .SMP_W  (SMP_W),
            .GAIN_W (GAIN_W),
            .FRAC   (FRAC)
        ) u_term (
            .diff   (ch_diff[c]),
            .gain   (ch_gain[c]),
            .tconst (ch_tc[c]),
            .term   (ch_term[c])
        );
    end

    logic signed [SMP_W:0]   err;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        err = (SMP_W+1)'(press_cur) - (SMP_W+1)'(press_ref);
        sum = SUM_W'(err) + SUM_W'(ch_term[CH_PRESS]) + SUM_W'(ch_term[CH_POWER]);
    end

    pr_out #(
        .SUM_W (SUM_W),
        .OUT_W (OUT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (cycle_tick),
        .valid      (in_valid),
        .sum        (sum),
        .deadband   (deadband),
        .impact     (impact),
        .impact_sat (impact_sat),
        .cmd_inc    (cmd_inc),
        .cmd_dec    (cmd_dec)
    );

endmodule

// File: tb/tb_turb_press_reg.sv
module tb_turb_press_reg;

    localparam int CLK_PERIOD = 10;
    localparam int SMP_W  = 16;
    localparam int GAIN_W = 16;
    localparam int FRAC   = 8;
    localparam int OUT_W  = 16;
    localparam longint Y_MAX = 32767;
    localparam longint Y_MIN = -32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cycle_tick = 1'b0;
    logic in_valid = 1'b0;
    logic signed [SMP_W-1:0]  press_cur = '0, press_ref = '0, power_cur = '0;
    logic signed [GAIN_W-1:0] press_gain = '0, press_tc = '0, power_gain = '0, power_tc = '0;
    logic [OUT_W-2:0]         deadband = '0;
    logic signed [OUT_W-1:0]  impact;
    logic impact_sat, cmd_inc, cmd_dec;

    always #(CLK_PERIOD/2) clk = ~clk;

    turb_press_reg #(
        .SMP_W(SMP_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(OUT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .in_valid(in_valid),
        .press_cur(press_cur), .press_ref(press_ref), .power_cur(power_cur),
        .press_gain(press_gain), .press_tc(press_tc),
        .power_gain(power_gain), .power_tc(power_tc),
        .deadband(deadband), .impact(impact), .impact_sat(impact_sat),
        .cmd_inc(cmd_inc), .cmd_dec(cmd_dec)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    longint m_y, m_prev_p, m_prev_n;
    bit m_sat, m_inc, m_dec, m_primed;
    logic [31:0] lfsr = 32'h1badf00d;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "impact", longint'(impact), m_y);
        chk(req, "impact_sat", longint'(impact_sat), longint'(m_sat));
        chk(req, "cmd_inc", longint'(cmd_inc), longint'(m_inc));
        chk(req, "cmd_dec", longint'(cmd_dec), longint'(m_dec));
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic model_tick(input bit v);
        longint p, r, n, dp, dn, tp, tn, y;
        if (!v) begin
            m_inc = 1'b0;
            m_dec = 1'b0;
            return;
        end
        p = longint'(press_cur);
        r = longint'(press_ref);
        n = longint'(power_cur);
        dp = m_primed ? p - m_prev_p : 0;
        dn = m_primed ? n - m_prev_n : 0;
        tp = (dp * longint'(press_gain) * longint'(press_tc)) >>> (2 * FRAC);
        tn = (dn * longint'(power_gain) * longint'(power_tc)) >>> (2 * FRAC);
        y = (p - r) + tp + tn;
        m_sat = (y > Y_MAX) || (y < Y_MIN);
        if (y > Y_MAX) y = Y_MAX;
        if (y < Y_MIN) y = Y_MIN;
        m_y = y;
        m_inc = y > longint'(deadband);
        m_dec = y < -longint'(deadband);
        m_prev_p = p;
        m_prev_n = n;
        m_primed = 1'b1;
    endtask

    task automatic load_samples(input bit big);
        lfsr = nxt(lfsr);
        if (big) begin
            press_cur = lfsr[15:0];
            power_cur = lfsr[31:16];
        end else begin
            press_cur = SMP_W'(signed'(lfsr[8:0]));
            power_cur = SMP_W'(signed'(lfsr[24:16]));
        end
        lfsr = nxt(lfsr);
        press_ref = big ? lfsr[15:0] : SMP_W'(signed'(lfsr[7:0]));
    endtask

    task automatic do_tick(input bit v, input string req);
        @(negedge clk);
        in_valid = v;
        cycle_tick = 1'b1;
        @(posedge clk);
        model_tick(v);
        @(negedge clk);
        cycle_tick = 1'b0;
        chk_all(req);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        cycle_tick = 1'b0;
        m_y = 0; m_sat = 0; m_inc = 0; m_dec = 0; m_primed = 0;
        m_prev_p = 0; m_prev_n = 0;
        @(negedge clk);
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int kg [6][4];
        kg[0] = '{256, 256, 256, 256};
        kg[1] = '{384, 512, -128, 300};
        kg[2] = '{-256, 640, 200, -700};
        kg[3] = '{1024, 1024, 768, 512};
        kg[4] = '{3, 5, 7, 11};
        kg[5] = '{0, 0, 0, 0};

        for (int cfg = 0; cfg < 6; cfg++) begin
            for (int dbi = 0; dbi < 3; dbi++) begin
                press_gain = GAIN_W'(kg[cfg][0]);
                press_tc   = GAIN_W'(kg[cfg][1]);
                power_gain = GAIN_W'(kg[cfg][2]);
                power_tc   = GAIN_W'(kg[cfg][3]);
                deadband   = (dbi == 0) ? 15'd0 : (dbi == 1) ? 15'd50 : 15'd1000;
                do_reset();
                // R3: first valid strobe with nonzero step from the zero-reset store
                load_samples(1'b0);
                press_cur = 16'sd400;
                power_cur = -16'sd300;
                do_tick(1'b1, "R3");
                for (int t = 0; t < 60; t++) begin
                    load_samples((t % 3) == 2);
                    if ((t % 5) == 4) begin
                        do_tick(1'b0, "R6");
                    end else begin
                        do_tick(1'b1, m_sat ? "R4" : "R2");
                        chk("R5", "cmd exclusive", longint'(cmd_inc && cmd_dec), 0);
                    end
                    // R7: idle cycle with changed inputs
                    load_samples(1'b1);
                    in_valid = (t % 2) == 0;
                    @(negedge clk);
                    chk_all("R7");
                end
            end
        end

        // R4: directed positive and negative clamping
        press_gain = 16'sd1024; press_tc = 16'sd1024;
        power_gain = 16'sd0;    power_tc = 16'sd0;
        deadband = 15'd0;
        do_reset();
        press_cur = -16'sd20000; press_ref = 16'sd0; power_cur = 16'sd0;
        do_tick(1'b1, "R4");
        press_cur = 16'sd20000;
        do_tick(1'b1, "R4");
        chk("R4", "high clamp", longint'(impact), Y_MAX);
        press_cur = -16'sd20000;
        do_tick(1'b1, "R4");
        chk("R4", "low clamp", longint'(impact), Y_MIN);

        // R5: deadband edges, no derivative (zero gains)
        press_gain = '0; power_gain = '0;
        deadband = 15'd100;
        press_ref = 16'sd0;
        press_cur = 16'sd100;  do_tick(1'b1, "R5");
        chk("R5", "inc at edge", longint'(cmd_inc), 0);
        press_cur = 16'sd101;  do_tick(1'b1, "R5");
        chk("R5", "inc above", longint'(cmd_inc), 1);
        press_cur = -16'sd100; do_tick(1'b1, "R5");
        chk("R5", "dec at edge", longint'(cmd_dec), 0);
        press_cur = -16'sd101; do_tick(1'b1, "R5");
        chk("R5", "dec below", longint'(cmd_dec), 1);

        // R6: invalid strobe right after reset must not arm the derivative
        press_gain = 16'sd256; press_tc = 16'sd256;
        do_reset();
        press_cur = 16'sd500; do_tick(1'b0, "R6");
        press_cur = 16'sd50;  do_tick(1'b1, "R6");
        chk("R6", "no kick after invalid", longint'(impact), 50);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule